// File: doc/BRIEF.md
# Match/Capture Timer Counter

A 32-bit timer/counter peripheral reached through a simple register port (byte address, write enable, write data, combinational read data). In timer mode a prescaler divides the clock, and the main counter advances each time the prescaler wraps. In counter mode the main counter advances on chosen edges of one of the four capture inputs, and the prescaler is ignored.

Four match channels compare the counter against their own compare values. On a match a channel can raise an interrupt flag, send the counter back to zero, or stop counting. It also updates its own external match output through a 2-bit action. Four capture channels copy the counter value on a selected edge of their input and can raise an interrupt flag. The capture inputs pass through a two-flop synchroniser before edge detection. A single interrupt line is high while any flag is set.

Top module: `mct_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `match_out` is zero.
- R2: Register word offsets (byte address): flags 0x00, control 0x04, counter 0x08, prescale limit 0x0C, prescale count 0x10, match control 0x14, compare values 0x18/0x1C/0x20/0x24, capture control 0x28, capture values 0x2C/0x30/0x34/0x38 (read-only), external match 0x3C, count control 0x70. Writable registers read back what was written. Any other address reads zero.
- R3: In timer mode with control bit 0 (enable) set and bit 1 clear, the prescale count increments once per clock. When the prescale count equals the prescale limit it returns to zero instead, and that same cycle is a count event that advances the counter by one.
- R4: A count event that finds the counter equal to compare value n is a match on channel n. If match control bit 3n is set, flag bit n is set. If bit 3n+1 is set, the counter goes to zero instead of incrementing.
- R5: If match control bit 3n+2 is set, a match on channel n holds the counter at its value and clears the control enable bit. When reset-on-match is also set, the counter goes to zero.
- R6: On each match on channel n, external output n (external match register bit n, driven on `match_out[n]`) is changed by the 2-bit action at bits 4+2n: 00 keeps it, 01 clears it, 10 sets it, 11 toggles it.
- R7: Capture channel n copies the counter into its capture value on a rising edge of `cap_in[n]` if capture control bit 3n is set, and on a falling edge if bit 3n+1 is set. Other edges are ignored. When bit 3n+2 is set a capture also sets flag bit 4+n.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. `irq` is high exactly while any flag bit is set.
- R9: While control bit 1 is set, the counter and the prescale count are held at zero, and writes to them have no effect.
- R10: Count control bits 1:0 select the mode: 00 timer, 01 rising edges, 10 falling edges, 11 both edges. Bits 3:2 select which `cap_in` line is the count source. In the counting modes each chosen edge on that line is a count event, edges on other lines do not count, and the prescale count does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 7 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cap_in | input | 4 | Capture / count inputs, asynchronous |
| match_out | output | 4 | External match outputs |
| irq | output | 1 | Interrupt, high while any flag is set |

## Verification
On every cycle the assertions check several local rules. The counter stays frozen between prescaler wraps. A reset-on-match lands on zero, and a stop-on-match drops the enable. The hold bit zeroes both counters. A capture stores the counter value from the previous cycle. A toggle action flips its output, and a full flag clear lowers the interrupt. The bench scenarios cover the end-to-end results that depend on longer histories: prescaled counter values after a known number of ticks, match periods, set/clear/toggle outcomes, edge selection through the synchroniser, counting on one chosen input while the others are ignored, and the register map itself.

// File: rtl/mct_pkg.sv
package mct_pkg;

    typedef enum logic [1:0] {
        CM_TIMER = 2'b00,
        CM_RISE  = 2'b01,
        CM_FALL  = 2'b10,
        CM_BOTH  = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        EA_KEEP   = 2'b00,
        EA_CLEAR  = 2'b01,
        EA_SET    = 2'b10,
        EA_TOGGLE = 2'b11
    } ext_act_e;

    // word indices of the register map
    localparam int unsigned WI_FLAGS  = 0;
    localparam int unsigned WI_CTRL   = 1;
    localparam int unsigned WI_TC     = 2;
    localparam int unsigned WI_PRE    = 3;
    localparam int unsigned WI_PCNT   = 4;
    localparam int unsigned WI_MCTL   = 5;
    localparam int unsigned WI_MATCH0 = 6;
    localparam int unsigned WI_CCTL   = 10;
    localparam int unsigned WI_CAP0   = 11;
    localparam int unsigned WI_EXT    = 15;
    localparam int unsigned WI_CNTCTL = 28;

endpackage

// File: rtl/mct_edge_sync.sv
module mct_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d      = q;
        d.s1   = din;
        d.s2   = q.s1;
        d.prev = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise = q.s2 & ~q.prev;
    assign fall = ~q.s2 & q.prev;

    // an edge pulse lasts one cycle: two rising pulses never follow each other
    assert_single_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    assert_single_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/mct_match_unit.sv
module mct_match_unit #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             count_ev,
    input  logic [CNT_W-1:0] tc,
    input  logic [CNT_W-1:0] cmp,
    input  logic [1:0]       act,
    input  logic             em_cur,
    output logic             hit,
    output logic             em_nx
);
    import mct_pkg::*;

    assign hit = count_ev && (tc == cmp);

    always_comb begin
        unique case (ext_act_e'(act))
            EA_KEEP:   em_nx = em_cur;
            EA_CLEAR:  em_nx = 1'b0;
            EA_SET:    em_nx = 1'b1;
            EA_TOGGLE: em_nx = ~em_cur;
            default:   em_nx = em_cur;
        endcase
    end

endmodule

// File: rtl/mct_timer.sv
module mct_timer #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [3:0]        cap_in,
    output logic [3:0]        match_out,
    output logic              irq
);
    import mct_pkg::*;

    localparam int unsigned N_CH  = 4;
    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam int unsigned FLG_W = 2 * N_CH;
    localparam int unsigned CTL_W = 3 * N_CH;
    localparam int unsigned ACT_W = 2 * N_CH;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [FLG_W-1:0]            flags;
        logic                        en;
        logic                        hold;
        logic [CNT_W-1:0]            tc;
        logic [CNT_W-1:0]            pre;
        logic [CNT_W-1:0]            pc;
        logic [CTL_W-1:0]            mctl;
        logic [CTL_W-1:0]            cctl;
        logic [N_CH-1:0][CNT_W-1:0]  cmp;
        logic [N_CH-1:0][CNT_W-1:0]  cap;
        logic [N_CH-1:0]             em;
        logic [ACT_W-1:0]            eact;
        logic [1:0]                  mode;
        logic [1:0]                  src;
    } state_t;

    state_t d, q;

    logic [IDX_W-1:0] widx;
    logic             unused_addr_lsb;
    assign widx            = bus_addr[ADDR_W-1:2];
    assign unused_addr_lsb = ^bus_addr[1:0];

    // ---------------------------------------------------------------
    // input synchronisers and edge detectors, one per capture line
    // ---------------------------------------------------------------
    logic [N_CH-1:0] rise, fall;

    for (genvar i = 0; i < N_CH; i++) begin : g_sync
        mct_edge_sync i_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (cap_in[i]),
            .rise (rise[i]),
            .fall (fall[i])
        );
    end

    // ---------------------------------------------------------------
    // count event
    // ---------------------------------------------------------------
    logic run, timer_mode, pre_wrap, src_edge, count_ev;

    always_comb begin
        run        = q.en && !q.hold;
        timer_mode = (q.mode == CM_TIMER);
        pre_wrap   = run && timer_mode && (q.pc == q.pre);
        unique case (cnt_mode_e'(q.mode))
            CM_RISE: src_edge = rise[q.src];
            CM_FALL: src_edge = fall[q.src];
            CM_BOTH: src_edge = rise[q.src] | fall[q.src];
            default: src_edge = 1'b0;
        endcase
        count_ev = timer_mode ? pre_wrap : (run && src_edge);
    end

    // ---------------------------------------------------------------
    // match channels
    // ---------------------------------------------------------------
    logic [N_CH-1:0] hit, em_nx, hit_rst, hit_stop, hit_int;
    logic [N_CH-1:0] cap_ev, cap_int;

    for (genvar i = 0; i < N_CH; i++) begin : g_match
        mct_match_unit #(.CNT_W(CNT_W)) i_match (
            .count_ev(count_ev),
            .tc      (q.tc),
            .cmp     (q.cmp[i]),
            .act     (q.eact[2*i +: 2]),
            .em_cur  (q.em[i]),
            .hit     (hit[i]),
            .em_nx   (em_nx[i])
        );
        assign hit_int[i]  = hit[i] & q.mctl[3*i];
        assign hit_rst[i]  = hit[i] & q.mctl[3*i+1];
        assign hit_stop[i] = hit[i] & q.mctl[3*i+2];
        assign cap_ev[i]   = (rise[i] & q.cctl[3*i]) | (fall[i] & q.cctl[3*i+1]);
        assign cap_int[i]  = cap_ev[i] & q.cctl[3*i+2];
    end

    // ---------------------------------------------------------------
    // next state
    // ---------------------------------------------------------------
    always_comb begin
        d = q;

        // register writes
        if (bus_we) begin
            if (widx == IDX_W'(WI_FLAGS))  d.flags = q.flags & ~bus_wdata[FLG_W-1:0];
            if (widx == IDX_W'(WI_CTRL)) begin
                d.en   = bus_wdata[0];
                d.hold = bus_wdata[1];
            end
            if (widx == IDX_W'(WI_TC))     d.tc   = bus_wdata;
            if (widx == IDX_W'(WI_PRE))    d.pre  = bus_wdata;
            if (widx == IDX_W'(WI_PCNT))   d.pc   = bus_wdata;
            if (widx == IDX_W'(WI_MCTL))   d.mctl = bus_wdata[CTL_W-1:0];
            if (widx == IDX_W'(WI_CCTL))   d.cctl = bus_wdata[CTL_W-1:0];
            if (widx == IDX_W'(WI_EXT)) begin
                d.em   = bus_wdata[N_CH-1:0];
                d.eact = bus_wdata[N_CH +: ACT_W];
            end
            if (widx == IDX_W'(WI_CNTCTL)) begin
                d.mode = bus_wdata[1:0];
                d.src  = bus_wdata[3:2];
            end
            for (int i = 0; i < N_CH; i++) begin
                if (widx == IDX_W'(WI_MATCH0 + i)) d.cmp[i] = bus_wdata;
            end
        end

        // prescaler
        if (run && timer_mode) d.pc = pre_wrap ? '0 : q.pc + ONE;

        // main counter and match actions
        if (count_ev) begin
            if (|hit_rst)       d.tc = '0;
            else if (|hit_stop) d.tc = q.tc;
            else                d.tc = q.tc + ONE;
            if (|hit_stop)      d.en = 1'b0;
        end

        for (int i = 0; i < N_CH; i++) begin
            if (hit[i])    d.em[i]        = em_nx[i];
            if (cap_ev[i]) d.cap[i]       = q.tc;
            d.flags[i]      = d.flags[i]      | hit_int[i];
            d.flags[N_CH+i] = d.flags[N_CH+i] | cap_int[i];
        end

        // hold-in-reset overrides everything on the counters
        if (q.hold) begin
            d.tc = '0;
            d.pc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // ---------------------------------------------------------------
    // read mux
    // ---------------------------------------------------------------
    always_comb begin
        bus_rdata = '0;
        if (widx == IDX_W'(WI_FLAGS))  bus_rdata = CNT_W'(q.flags);
        if (widx == IDX_W'(WI_CTRL))   bus_rdata = CNT_W'({q.hold, q.en});
        if (widx == IDX_W'(WI_TC))     bus_rdata = q.tc;
        if (widx == IDX_W'(WI_PRE))    bus_rdata = q.pre;
        if (widx == IDX_W'(WI_PCNT))   bus_rdata = q.pc;
        if (widx == IDX_W'(WI_MCTL))   bus_rdata = CNT_W'(q.mctl);
        if (widx == IDX_W'(WI_CCTL))   bus_rdata = CNT_W'(q.cctl);
        if (widx == IDX_W'(WI_EXT))    bus_rdata = CNT_W'({q.eact, q.em});
        if (widx == IDX_W'(WI_CNTCTL)) bus_rdata = CNT_W'({q.src, q.mode});
        for (int i = 0; i < N_CH; i++) begin
            if (widx == IDX_W'(WI_MATCH0 + i)) bus_rdata = q.cmp[i];
            if (widx == IDX_W'(WI_CAP0 + i))   bus_rdata = q.cap[i];
        end
    end

    assign match_out = q.em;
    assign irq       = |q.flags;

    // ---------------------------------------------------------------
    // assertions
    // ---------------------------------------------------------------
    logic wr_tc, wr_flags_all;
    assign wr_tc        = bus_we && (widx == IDX_W'(WI_TC));
    assign wr_flags_all = bus_we && (widx == IDX_W'(WI_FLAGS)) && (&bus_wdata[FLG_W-1:0]);

    assert_prescale_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_mode && !q.hold && (q.pc != q.pre) && !wr_tc) |=> (q.tc == $past(q.tc)));

    assert_reset_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_ev && |hit_rst) |=> (q.tc == '0));

    assert_stop_drops_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_ev && |hit_stop) |=> !q.en);

    assert_hold_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.hold |=> (q.tc == '0 && q.pc == '0));

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flags_all && !(|hit_int) && !(|cap_int)) |=> !irq);

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        assert_toggle_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && q.eact[2*i +: 2] == EA_TOGGLE) |=> (match_out[i] != $past(match_out[i])));
        assert_capture_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
            cap_ev[i] |=> (q.cap[i] == $past(q.tc)));
    end

endmodule

// File: tb/test_mct_timer.sv
module test_mct_timer;

    localparam int PERIOD = 10;

    localparam logic [6:0] A_FLAGS = 7'h00, A_CTRL = 7'h04, A_TC = 7'h08, A_PRE = 7'h0C,
                           A_PCNT = 7'h10, A_MCTL = 7'h14, A_M0 = 7'h18, A_M1 = 7'h1C,
                           A_M3 = 7'h24, A_CCTL = 7'h28, A_C0 = 7'h2C, A_C1 = 7'h30,
                           A_C2 = 7'h34, A_EXT = 7'h3C, A_CNTCTL = 7'h70;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  cap_in = '0;
    logic [3:0]  match_out;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    mct_timer i_mct_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
        .match_out(match_out), .irq(irq)
    );

    // timer-mode scenarios: prescale, compare 0, match control ch0, action ch0,
    // initial output, ticks, then expected counter, prescale count, flag, output
    typedef struct packed {
        logic [7:0]  pre;
        logic [15:0] cmp0;
        logic [2:0]  mctl;
        logic [1:0]  act;
        logic        em0;
        logic [7:0]  ticks;
        logic [15:0] exp_tc;
        logic [7:0]  exp_pc;
        logic        exp_flag;
        logic        exp_em;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{8'd0, 16'd1000, 3'b000, 2'd0, 1'b0, 8'd10, 16'd10, 8'd0, 1'b0, 1'b0}, // R3 plain
        '{8'd3, 16'd1000, 3'b000, 2'd0, 1'b0, 8'd10, 16'd2,  8'd2, 1'b0, 1'b0}, // R3 divide by 4
        '{8'd0, 16'd4,    3'b011, 2'd3, 1'b0, 8'd7,  16'd2,  8'd0, 1'b1, 1'b1}, // R4 R6 toggle
        '{8'd0, 16'd4,    3'b100, 2'd2, 1'b0, 8'd10, 16'd4,  8'd0, 1'b0, 1'b1}, // R5 R6 set
        '{8'd1, 16'd2,    3'b011, 2'd1, 1'b1, 8'd9,  16'd1,  8'd1, 1'b1, 1'b0}, // R3 R4 R6 clear
        '{8'd0, 16'd0,    3'b001, 2'd3, 1'b0, 8'd3,  16'd3,  8'd0, 1'b1, 1'b1}, // R4 int only
        '{8'd0, 16'd2,    3'b110, 2'd0, 1'b0, 8'd8,  16'd0,  8'd0, 1'b0, 1'b0}  // R5 stop+reset
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = v;
        bus_we    = 1'b1;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_sync();
        repeat (5) @(posedge clk);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd(7'(a * 4), r);
            chk("R1 reset register", r, 32'h0);
        end
        rd(A_CNTCTL, r);
        chk("R1 reset count control", r, 32'h0);
        chk("R1 reset irq", {31'b0, irq}, 32'h0);
        chk("R1 reset match_out", {28'b0, match_out}, 32'h0);

        // table walk: R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            wr(A_CTRL, 32'h2);
            wr(A_CTRL, 32'h0);
            wr(A_FLAGS, 32'hFF);
            wr(A_PRE, 32'(VEC[v].pre));
            wr(A_M0, 32'(VEC[v].cmp0));
            wr(A_MCTL, 32'(VEC[v].mctl));
            wr(A_EXT, (32'(VEC[v].act) << 4) | 32'(VEC[v].em0));
            wr(A_CTRL, 32'h1);
            repeat (int'(VEC[v].ticks) - 1) @(posedge clk);
            wr(A_CTRL, 32'h0);
            rd(A_TC, r);
            chk("R3 R4 R5 vector counter", r, 32'(VEC[v].exp_tc));
            rd(A_PCNT, r);
            chk("R3 vector prescale count", r, 32'(VEC[v].exp_pc));
            rd(A_FLAGS, r);
            chk("R4 vector flags", r, 32'(VEC[v].exp_flag));
            chk("R8 vector irq", {31'b0, irq}, 32'(VEC[v].exp_flag));
            chk("R6 vector match_out0", {31'b0, match_out[0]}, 32'(VEC[v].exp_em));
        end

        // R5 stop on channel 1 clears enable
        wr(A_CTRL, 32'h2);
        wr(A_CTRL, 32'h0);
        wr(A_FLAGS, 32'hFF);
        wr(A_PRE, 32'h0);
        wr(A_EXT, 32'h0);
        wr(A_MCTL, 32'h20);
        wr(A_M1, 32'd3);
        wr(A_CTRL, 32'h1);
        repeat (20) @(posedge clk);
        rd(A_CTRL, r);
        chk("R5 enable cleared by stop", r, 32'h0);
        rd(A_TC, r);
        chk("R5 counter stopped at compare", r, 32'd3);

        // R8 write-one-to-clear
        wr(A_MCTL, 32'h1);
        wr(A_M0, 32'd0);
        wr(A_CTRL, 32'h2);
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h1);
        wr(A_CTRL, 32'h0);
        wr(A_FLAGS, 32'h0);
        rd(A_FLAGS, r);
        chk("R8 write zero keeps flag", r, 32'h1);
        wr(A_FLAGS, 32'hFE);
        rd(A_FLAGS, r);
        chk("R8 other bits keep flag", r, 32'h1);
        chk("R8 irq while flagged", {31'b0, irq}, 32'h1);
        wr(A_FLAGS, 32'h1);
        rd(A_FLAGS, r);
        chk("R8 write one clears flag", r, 32'h0);
        chk("R8 irq low after clear", {31'b0, irq}, 32'h0);

        // R7 capture edges
        wr(A_MCTL, 32'h0);
        wr(A_TC, 32'h55);
        wr(A_CCTL, 32'h28);
        @(negedge clk); cap_in[1] = 1'b1;
        wait_sync();
        rd(A_C1, r);
        chk("R7 rising capture value", r, 32'h55);
        rd(A_FLAGS, r);
        chk("R7 capture flag bit 5", r, 32'h20);
        chk("R8 irq from capture", {31'b0, irq}, 32'h1);
        wr(A_FLAGS, 32'h20);
        wr(A_TC, 32'h66);
        @(negedge clk); cap_in[1] = 1'b0;
        wait_sync();
        rd(A_C1, r);
        chk("R7 falling edge ignored", r, 32'h55);
        rd(A_FLAGS, r);
        chk("R7 no flag on ignored edge", r, 32'h0);
        wr(A_CCTL, 32'h80);
        @(negedge clk); cap_in[2] = 1'b1;
        wait_sync();
        rd(A_C2, r);
        chk("R7 rising ignored on falling-only", r, 32'h0);
        wr(A_TC, 32'h77);
        @(negedge clk); cap_in[2] = 1'b0;
        wait_sync();
        rd(A_C2, r);
        chk("R7 falling capture value", r, 32'h77);
        rd(A_FLAGS, r);
        chk("R7 no flag without interrupt bit", r, 32'h0);

        // R10 counter mode, both edges on line 3
        wr(A_CCTL, 32'h0);
        wr(A_CNTCTL, 32'hF);
        wr(A_CTRL, 32'h2);
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h1);
        for (int t = 0; t < 3; t++) begin
            @(negedge clk); cap_in[3] = ~cap_in[3];
            wait_sync();
        end
        rd(A_TC, r);
        chk("R10 both-edge count", r, 32'd3);
        rd(A_PCNT, r);
        chk("R10 prescale idle in counter mode", r, 32'd0);
        wr(A_CTRL, 32'h2);
        wr(A_CTRL, 32'h0);
        wr(A_CNTCTL, 32'hD);
        wr(A_CTRL, 32'h1);
        for (int t = 0; t < 4; t++) begin
            @(negedge clk); cap_in[3] = ~cap_in[3];
            wait_sync();
        end
        for (int t = 0; t < 2; t++) begin
            @(negedge clk); cap_in[0] = ~cap_in[0];
            wait_sync();
        end
        rd(A_TC, r);
        chk("R10 rising-only count, other line ignored", r, 32'd2);

        // R9 hold
        wr(A_CNTCTL, 32'h0);
        wr(A_CTRL, 32'h3);
        repeat (10) @(posedge clk);
        wr(A_TC, 32'h7);
        wr(A_PCNT, 32'h5);
        repeat (2) @(posedge clk);
        rd(A_TC, r);
        chk("R9 counter held at zero", r, 32'h0);
        rd(A_PCNT, r);
        chk("R9 prescale held at zero", r, 32'h0);
        wr(A_CTRL, 32'h0);

        // R2 readback and map
        wr(A_PRE, 32'hA5A5);
        rd(A_PRE, r);
        chk("R2 prescale readback", r, 32'hA5A5);
        wr(A_M3, 32'h12345678);
        rd(A_M3, r);
        chk("R2 compare 3 readback", r, 32'h12345678);
        wr(A_EXT, 32'hABC);
        rd(A_EXT, r);
        chk("R2 external match readback", r, 32'hABC);
        chk("R6 match_out from register", {28'b0, match_out}, 32'hC);
        wr(A_C0, 32'hDEAD);
        rd(A_C0, r);
        chk("R2 capture value read-only", r, 32'h0);
        rd(7'h40, r);
        chk("R2 unmapped 0x40 reads zero", r, 32'h0);
        rd(7'h6C, r);
        chk("R2 unmapped 0x6C reads zero", r, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule